// File: doc/BRIEF.md
# Instruction Address Translation with Two-Level TLB Refill

This block turns the virtual page number of an instruction fetch into a physical frame number for 4 KB pages. A small fully associative first-level table answers most lookups. Behind it sits a larger four-way set-associative second-level table. When the first level misses and the second level hits, the first level is refilled after a fixed two-cycle load. When both levels miss, the block issues a request to an external page-table walker. A successful walk result is installed in both levels. A walk that reports a non-present page is passed to fetch as a fault, and nothing is installed.

Fetch offers a request with a ready/valid handshake. Only one translation is in flight at a time, so `req_ready` stays low until the answer is returned. A flush input clears every valid bit in both levels in a single cycle.

Top module: `itlb_refill`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `walk_req_valid` are 0. Both levels hold no valid entry, so the first lookup of any page goes to the walker.
- R2: `req_ready` is 1 only while no translation is in flight and `flush` is low. It stays 0 from the accepting cycle until the cycle in which `rsp_valid` is high.
- R3: A first-level hit accepted in cycle c gives `rsp_valid`=1, `rsp_fault`=0 and the stored frame number in cycle c+1.
- R4: A first-level miss that hits in the second level gives its answer in cycle c+3. The entry is then copied into the first level, so the next lookup of that page is a first-level hit.
- R5: When both levels miss, `walk_req_valid` rises in cycle c+2 with `walk_req_vpn` equal to the requested page. It stays high with a stable page number until `walk_rsp_valid` is seen.
- R6: A walk response with `walk_rsp_fault`=0 in cycle w gives `rsp_valid`=1 with that frame number in cycle w+1. The mapping is installed in both levels.
- R7: A walk response with `walk_rsp_fault`=1 gives `rsp_fault`=1 and `rsp_pfn`=0 in the next cycle. Neither level is written, so a repeat lookup of that page walks again.
- R8: The first level holds 16 entries and replaces them round robin. After 16 further installs, a page drops out of the first level but is still answered by the second level.
- R9: The second level has 128 sets of 4 ways, indexed by page-number bits [6:0]. An install fills invalid ways first, then evicts the tree pseudo-LRU way. After four installs into an empty set, a fifth install evicts the first one.
- R10: A one-cycle `flush` pulse invalidates every entry in both levels, so each page seen before it walks again. An install that falls in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries of both levels |
| req_valid | input | 1 | Fetch offers a page number |
| req_ready | output | 1 | Block can accept a request |
| req_vpn | input | 36 | Virtual page number to translate |
| rsp_valid | output | 1 | One-cycle pulse carrying the answer |
| rsp_pfn | output | 24 | Physical frame number (0 on fault) |
| rsp_fault | output | 1 | Page not present |
| walk_req_valid | output | 1 | Walk request, held until answered |
| walk_req_vpn | output | 36 | Page number to walk |
| walk_rsp_valid | input | 1 | Walker answer strobe |
| walk_rsp_pfn | input | 24 | Frame number from the walker |
| walk_rsp_fault | input | 1 | Walker reports page not present |

## Verification
Each outcome has a fixed latency, counted from the accepting clock edge. A first-level hit answers on that same edge, a second-level hit two edges later, and a walk answers on the edge that samples the walker strobe. The walk request is due one edge after acceptance. The bench keeps a posedge counter and records the edge that will accept the request, then samples every output at the falling edge. It compares the exact edge at which `rsp_valid` is seen with the value due for the expected outcome. This separates the three paths. Replacement and flush behaviour show up only as a change in which latency a later lookup takes.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

    typedef enum logic [1:0] {
        XL_IDLE,
        XL_L2_LOOK,
        XL_L1_FILL,
        XL_WALK
    } xl_state_e;

endpackage

// File: rtl/itlb_l1_cam.sv
module itlb_l1_cam #(
    parameter int VPN_W   = 36,
    parameter int PFN_W   = 24,
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PFN_W-1:0] ins_pfn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
        logic [PTR_W-1:0]              ptr;
    } l1_state_t;

    l1_state_t cam_d, cam_q;

    // Parallel compare across every entry
    always_comb begin
        lk_hit = 1'b0;
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (cam_q.valid[i] && cam_q.vpn[i] == lk_vpn) begin
                lk_hit = 1'b1;
                lk_pfn = lk_pfn | cam_q.pfn[i];
            end
        end
    end

    always_comb begin
        cam_d = cam_q;
        if (ins_en) begin
            cam_d.valid[cam_q.ptr] = 1'b1;
            cam_d.vpn[cam_q.ptr]   = ins_vpn;
            cam_d.pfn[cam_q.ptr]   = ins_pfn;
            cam_d.ptr = (cam_q.ptr == PTR_W'(ENTRIES - 1)) ? '0 : cam_q.ptr + PTR_W'(1);
        end
        if (flush) begin
            cam_d.valid = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cam_q <= '0;
        end else begin
            cam_q <= cam_d;
        end
    end

endmodule

// File: rtl/itlb_l2_sa.sv
module itlb_l2_sa #(
    parameter int VPN_W = 36,
    parameter int PFN_W = 24,
    parameter int SETS  = 128,
    parameter int WAYS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_touch,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             ins_en,
    input  logic [PFN_W-1:0] ins_pfn
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0] valid;
        logic [SETS-1:0][WAYS-2:0] tree;
    } l2_state_t;

    l2_state_t st_d, st_q;

    logic [TAG_W-1:0] tag_mem [SETS][WAYS];
    logic [PFN_W-1:0] pfn_mem [SETS][WAYS];

    logic [IDX_W-1:0] set_idx;
    logic [TAG_W-1:0] set_tag;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] ins_way;
    logic             has_free;

    assign set_idx = lk_vpn[IDX_W-1:0];
    assign set_tag = lk_vpn[VPN_W-1:IDX_W];

    // Mark the path to the used way so the tree points away from it
    function automatic logic [WAYS-2:0] tree_touch(input logic [WAYS-2:0] t,
                                                   input logic [WAY_W-1:0] way);
        logic [WAYS-2:0] r;
        int node;
        r    = t;
        node = 0;
        for (int l = 0; l < WAY_W; l++) begin
            r[node] = ~way[WAY_W-1-l];
            node    = 2 * node + 1 + int'(way[WAY_W-1-l]);
        end
        return r;
    endfunction

    function automatic logic [WAY_W-1:0] tree_victim(input logic [WAYS-2:0] t);
        int node;
        node = 0;
        for (int l = 0; l < WAY_W; l++) begin
            node = 2 * node + 1 + int'(t[node]);
        end
        return WAY_W'(node - (WAYS - 1));
    endfunction

    always_comb begin
        lk_hit  = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (st_q.valid[set_idx][w] && tag_mem[set_idx][w] == set_tag) begin
                lk_hit  = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
        lk_pfn = pfn_mem[set_idx][hit_way];
    end

    // Victim choice: lowest free way, else the tree's pick
    always_comb begin
        has_free = 1'b0;
        ins_way  = tree_victim(st_q.tree[set_idx]);
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!st_q.valid[set_idx][w]) begin
                has_free = 1'b1;
                ins_way  = WAY_W'(w);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (lk_touch && lk_hit) begin
            st_d.tree[set_idx] = tree_touch(st_q.tree[set_idx], hit_way);
        end
        if (ins_en) begin
            st_d.valid[set_idx][ins_way] = 1'b1;
            st_d.tree[set_idx]           = tree_touch(st_q.tree[set_idx], ins_way);
        end
        if (flush) begin
            st_d.valid = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            tag_mem[set_idx][ins_way] <= set_tag;
            pfn_mem[set_idx][ins_way] <= ins_pfn;
        end
    end

endmodule

// File: rtl/itlb_refill.sv
module itlb_refill
    import itlb_pkg::*;
#(
    parameter int VPN_W      = 36,
    parameter int PFN_W      = 24,
    parameter int L1_ENTRIES = 16,
    parameter int L2_SETS    = 128,
    parameter int L2_WAYS    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             rsp_valid,
    output logic [PFN_W-1:0] rsp_pfn,
    output logic             rsp_fault,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_req_vpn,
    input  logic             walk_rsp_valid,
    input  logic [PFN_W-1:0] walk_rsp_pfn,
    input  logic             walk_rsp_fault
);
    typedef struct packed {
        xl_state_e        state;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             rsp_valid;
        logic [PFN_W-1:0] rsp_pfn;
        logic             rsp_fault;
    } xl_regs_t;

    xl_regs_t r_d, r_q;

    logic             l1_hit;
    logic [PFN_W-1:0] l1_pfn;
    logic             l1_ins;
    logic             l2_hit;
    logic [PFN_W-1:0] l2_pfn;
    logic             l2_touch;
    logic             l2_ins;
    logic [PFN_W-1:0] ins_pfn;

    assign req_ready      = (r_q.state == XL_IDLE) && !flush;
    assign rsp_valid      = r_q.rsp_valid;
    assign rsp_pfn        = r_q.rsp_pfn;
    assign rsp_fault      = r_q.rsp_fault;
    assign walk_req_valid = (r_q.state == XL_WALK);
    assign walk_req_vpn   = r_q.vpn;

    itlb_l1_cam #(
        .VPN_W  (VPN_W),
        .PFN_W  (PFN_W),
        .ENTRIES(L1_ENTRIES)
    ) u_l1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .lk_vpn (req_vpn),
        .lk_hit (l1_hit),
        .lk_pfn (l1_pfn),
        .ins_en (l1_ins),
        .ins_vpn(r_q.vpn),
        .ins_pfn(ins_pfn)
    );

    itlb_l2_sa #(
        .VPN_W(VPN_W),
        .PFN_W(PFN_W),
        .SETS (L2_SETS),
        .WAYS (L2_WAYS)
    ) u_l2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .lk_vpn  (r_q.vpn),
        .lk_touch(l2_touch),
        .lk_hit  (l2_hit),
        .lk_pfn  (l2_pfn),
        .ins_en  (l2_ins),
        .ins_pfn (ins_pfn)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        r_d.rsp_fault = 1'b0;
        l1_ins        = 1'b0;
        l2_ins        = 1'b0;
        l2_touch      = 1'b0;
        ins_pfn       = r_q.pfn;
        unique case (r_q.state)
            XL_IDLE: begin
                if (req_valid && req_ready) begin
                    if (l1_hit) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_pfn   = l1_pfn;
                    end else begin
                        r_d.vpn   = req_vpn;
                        r_d.state = XL_L2_LOOK;
                    end
                end
            end
            XL_L2_LOOK: begin
                if (l2_hit) begin
                    l2_touch  = 1'b1;
                    r_d.pfn   = l2_pfn;
                    r_d.state = XL_L1_FILL;
                end else begin
                    r_d.state = XL_WALK;
                end
            end
            XL_L1_FILL: begin
                l1_ins        = !flush;
                r_d.rsp_valid = 1'b1;
                r_d.rsp_pfn   = r_q.pfn;
                r_d.state     = XL_IDLE;
            end
            XL_WALK: begin
                ins_pfn = walk_rsp_pfn;
                if (walk_rsp_valid) begin
                    r_d.rsp_valid = 1'b1;
                    r_d.state     = XL_IDLE;
                    if (walk_rsp_fault) begin
                        r_d.rsp_fault = 1'b1;
                        r_d.rsp_pfn   = '0;
                    end else begin
                        r_d.rsp_pfn = walk_rsp_pfn;
                        l1_ins      = !flush;
                        l2_ins      = !flush;
                    end
                end
            end
            default: r_d.state = XL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/itlb_refill_chk.sv
module itlb_refill_chk #(
    parameter int VPN_W = 36,
    parameter int PFN_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [PFN_W-1:0] rsp_pfn,
    input logic             rsp_fault,
    input logic             walk_req_valid,
    input logic [VPN_W-1:0] walk_req_vpn,
    input logic             walk_rsp_valid,
    input logic [PFN_W-1:0] walk_rsp_pfn,
    input logic             walk_rsp_fault
);
    // R2
    flush_blocks_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !req_ready);

    // R2
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !req_ready);

    // R5
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_rsp_valid) |=> (walk_req_valid && $stable(walk_req_vpn)));

    // R6
    walk_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid && !walk_rsp_fault)
            |=> (rsp_valid && !rsp_fault && rsp_pfn == $past(walk_rsp_pfn)));

    // R7
    fault_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid && walk_rsp_fault)
            |=> (rsp_valid && rsp_fault && rsp_pfn == '0));

    // R7
    fault_zero_pfn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pfn == '0));

endmodule

bind itlb_refill itlb_refill_chk #(
    .VPN_W(VPN_W),
    .PFN_W(PFN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_pfn       (rsp_pfn),
    .rsp_fault     (rsp_fault),
    .walk_req_valid(walk_req_valid),
    .walk_req_vpn  (walk_req_vpn),
    .walk_rsp_valid(walk_rsp_valid),
    .walk_rsp_pfn  (walk_rsp_pfn),
    .walk_rsp_fault(walk_rsp_fault)
);

// File: tb/itlb_refill_bench.sv
module itlb_refill_bench;
    localparam int VW   = 36;
    localparam int PW   = 24;
    localparam int WLAT = 3;
    localparam int K_L1 = 0, K_L2 = 1, K_WALK = 2, K_FAULT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [VW-1:0] req_vpn = '0;
    logic rsp_valid;
    logic [PW-1:0] rsp_pfn;
    logic rsp_fault;
    logic walk_req_valid;
    logic [VW-1:0] walk_req_vpn;
    logic walk_rsp_valid = 1'b0;
    logic [PW-1:0] walk_rsp_pfn = '0;
    logic walk_rsp_fault = 1'b0;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    int walk_start = -1;
    int walk_edge = -1;
    int walk_vpn_ok = 0;
    logic [VW-1:0] fault_vpn = '1;
    logic done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    itlb_refill u_itlb_refill (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
        .rsp_valid(rsp_valid), .rsp_pfn(rsp_pfn), .rsp_fault(rsp_fault),
        .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pfn(walk_rsp_pfn),
        .walk_rsp_fault(walk_rsp_fault)
    );

    function automatic logic [PW-1:0] frame_of(input logic [VW-1:0] v);
        return v[PW-1:0] ^ 24'h3C5AA5 ^ {12'h000, v[VW-1:PW]};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Walker model: answers WLAT cycles after it sees a request
    initial begin
        forever begin
            @(negedge clk);
            if (walk_req_valid) begin
                logic [VW-1:0] wv;
                wv = walk_req_vpn;
                walk_start = cyc;
                repeat (WLAT) begin
                    @(negedge clk);
                    if (walk_req_vpn != wv || !walk_req_valid) walk_vpn_ok = 0;
                end
                walk_rsp_valid = 1'b1;
                walk_rsp_fault = (wv == fault_vpn);
                walk_rsp_pfn   = (wv == fault_vpn) ? 24'hFFFFFF : frame_of(wv);
                walk_edge      = cyc + 1;
                @(negedge clk);
                walk_rsp_valid = 1'b0;
                walk_rsp_fault = 1'b0;
            end
        end
    end

    // Issue one request, then check its latency path, frame and fault flag
    task automatic xlate(input logic [VW-1:0] v, input int kind, input string req);
        int acc;
        int got;
        bit busy_ok;
        @(negedge clk);
        req_valid   = 1'b1;
        req_vpn     = v;
        walk_edge   = -1;
        walk_start  = -1;
        walk_vpn_ok = 1;
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = 1'b1;
        while (!rsp_valid) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
        end
        got = cyc;
        check(busy_ok, "R2 ready low while busy", busy_ok, 1);
        case (kind)
            K_L1: check(got == acc, {req, " L1 hit edge"}, got - acc, 0);
            K_L2: check(got == acc + 2, {req, " L2 hit edge"}, got - acc, 2);
            default: begin
                check(walk_start == acc + 1, "R5 walk request edge", walk_start - acc, 1);
                check(walk_vpn_ok == 1, "R5 walk vpn held", walk_vpn_ok, 1);
                check(got == walk_edge, {req, " walk answer edge"}, got, walk_edge);
            end
        endcase
        if (kind == K_FAULT) begin
            check(rsp_fault && rsp_pfn == '0, {req, " fault"}, {rsp_fault, rsp_pfn}, {1'b1, 24'h0});
        end else begin
            check(!rsp_fault && rsp_pfn == frame_of(v), {req, " frame"}, rsp_pfn, frame_of(v));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !walk_req_valid, "R1 reset outputs",
              {req_ready, rsp_valid, walk_req_valid}, 3'b100);
        xlate(36'h0_0001_2345, K_WALK, "R1 empty after reset");
    endtask

    task automatic t_hits();
        xlate(36'h0_0001_2345, K_L1, "R3 repeat");
        xlate(36'h0_00AB_CDEF, K_WALK, "R6 install B");
        xlate(36'hF_0000_0777, K_WALK, "R6 install C");
        xlate(36'h0_00AB_CDEF, K_L1, "R3 B");
        xlate(36'hF_0000_0777, K_L1, "R6 C in L1");
    endtask

    task automatic t_fault();
        fault_vpn = 36'h0_0BAD_0000;
        xlate(fault_vpn, K_FAULT, "R7 first");
        xlate(fault_vpn, K_FAULT, "R7 no install");
        fault_vpn = '1;
    endtask

    task automatic t_l1_evict();
        for (int i = 0; i < 16; i++) xlate(36'h2_0000_0100 + VW'(i), K_WALK, "R8 fill");
        xlate(36'h0_0001_2345, K_L2, "R8 evicted to L2");
        xlate(36'h0_0001_2345, K_L1, "R4 refilled");
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush = 1'b1;
        #1;
        check(!req_ready, "R2 ready low on flush", req_ready, 0);
        @(negedge clk);
        flush = 1'b0;
        xlate(36'h0_0001_2345, K_WALK, "R10 A after flush");
        xlate(36'h0_00AB_CDEF, K_WALK, "R10 B after flush");
    endtask

    task automatic t_plru();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int k = 1; k <= 5; k++) xlate(VW'(5 + 128 * k), K_WALK, "R9 set fill");
        for (int i = 0; i < 16; i++) xlate(VW'(32'h1000 + 32 + i), K_WALK, "R9 L1 push");
        xlate(VW'(5 + 128 * 2), K_L2, "R9 way kept");
        xlate(VW'(5 + 128 * 5), K_L2, "R9 newest kept");
        xlate(VW'(5 + 128 * 1), K_WALK, "R9 oldest evicted");
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hits();
        t_fault();
        t_l1_evict();
        t_flush();
        t_plru();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule